// File: doc/BRIEF.md
# Dataway Function Controller for a Multi-Channel Counter Bank

This block sits between a crate dataway and a bank of twelve counters. It watches the station-select line, the 4-bit subaddress and the 5-bit function code. It answers every command with the command-accepted response (X) and the condition response (Q). It points the bank's read multiplexer at the addressed channel while the first strobe (S1) is high. When the second strobe (S2) rises, it fires single-cycle clear or increment pulses into the bank. The crate-wide clear, initialize and inhibit lines act on the bank through this block as well.

The block also owns the attention request (LAM). A LAM flag latches on the first overflow-warning flag that any channel raises, and it stays set until the module is cleared. A separate enable latch gates the request onto the dataway. The enable is set and cleared by explicit commands and is also cleared by initialize. The request is masked while the station is selected. A test command reports the flag without regard to the enable.

A three-state machine follows the strobes, using only the rising edge of S2 for actions:
- PH_IDLE: both strobes low.
- PH_S1: S1 high, S2 low.
- PH_S2: S2 high.

Transitions:
- IDLE→S1 on S1.
- IDLE→S2 and S1→S2 on S2. Each of these is the action edge.
- S2→S2 while S2 stays high.
- S2→S1 when S2 falls while S1 is held.
- S2→IDLE when both strobes are low.
- S1→IDLE when S1 falls.

Top module: `dw_func_ctrl`

## Requirements
- R1: After reset, the clear and increment pulses are 0, the LAM flag and the LAM enable are 0, `lam_req` is 0, and with `stn_sel` low both `x_resp` and `q_resp` are 0.
- R2: With `stn_sel` high, function 0 or 2 and subaddress 0 to 11 (binary), `q_resp` and `x_resp` are 1. `rd_sel` equals the subaddress. `rd_en` is 1 while `strobe1` is high.
- R3: Function 2 at subaddress 11 gives exactly one `clr_pulse` on the rising edge of S2. Function 2 at any other subaddress gives no clear.
- R4: Function 8 returns `q_resp` equal to the LAM flag, whatever the enable state, with `x_resp` 1.
- R5: Function 9 with S2 gives one `clr_pulse` and clears the LAM flag.
- R6: Function 25 with S2 gives one `inc_pulse` and no `clr_pulse`.
- R7: Function 26 with S2 sets the LAM enable and function 24 with S2 clears it. The enable holds across any other command, including crate clear.
- R8: `x_resp` is 1 only for `stn_sel` high, function in {0,2,8,9,24,25,26} and subaddress below 12. `q_resp` is 0 whenever R2 and R4 do not apply.
- R9: Crate clear or initialize, at the S2 rise, gives one `clr_pulse` and clears the LAM flag, whether or not `stn_sel` is high. Initialize also clears the LAM enable; crate clear does not.
- R10: Any bit of `half_flags` sets the LAM flag, which holds until a module clear. `lam_req` is the flag AND the enable AND NOT `stn_sel`.
- R11: A warning flag still high during the clear pulse does not set the LAM flag again. The clear wins.
- R12: `bank_inhibit` follows `crate_inhibit` in the same cycle.
- R13: Holding S2 high for several cycles yields only one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stn_sel | input | 1 | Station select (N) |
| sub_addr | input | 4 | Subaddress (A) |
| func | input | 5 | Function code (F) |
| strobe1 | input | 1 | First strobe (S1) |
| strobe2 | input | 1 | Second strobe (S2) |
| crate_clear | input | 1 | Crate-wide clear (C) |
| crate_init | input | 1 | Crate-wide initialize (Z) |
| crate_inhibit | input | 1 | Crate-wide inhibit (I) |
| half_flags | input | 12 | Per-channel overflow-warning flags |
| x_resp | output | 1 | Command accepted |
| q_resp | output | 1 | Condition response |
| rd_en | output | 1 | Read multiplexer enable |
| rd_sel | output | 4 | Read multiplexer channel select |
| clr_pulse | output | 1 | Clear all channels, one cycle |
| inc_pulse | output | 1 | Increment all channels, one cycle |
| bank_inhibit | output | 1 | Common inhibit to the counter bank |
| lam_req | output | 1 | Attention request to the dataway |

## Verification
Two events can land in the same cycle: the LAM-setting path, driven by a warning flag that is still high, and the module-clear path, driven by the clear pulse. The bench holds a warning flag high through a crate-clear action, as a counter bank does before its own clear has taken effect. It then requires the LAM flag to stay low both during the clear pulse and on the cycle after it. The flag is read back through `lam_req` with the station deselected and through the test function. Function decoding is swept over all function and subaddress codes, with the station both selected and deselected.

// File: rtl/dw_func_pkg.sv
package dw_func_pkg;
    localparam int FN_W = 5;

    localparam logic [FN_W-1:0] FN_READ     = 5'd0;
    localparam logic [FN_W-1:0] FN_READ_CLR = 5'd2;
    localparam logic [FN_W-1:0] FN_TEST_LAM = 5'd8;
    localparam logic [FN_W-1:0] FN_CLEAR    = 5'd9;
    localparam logic [FN_W-1:0] FN_LAM_OFF  = 5'd24;
    localparam logic [FN_W-1:0] FN_INCR     = 5'd25;
    localparam logic [FN_W-1:0] FN_LAM_ON   = 5'd26;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_S1   = 2'd1,
        PH_S2   = 2'd2
    } phase_t;

    typedef struct packed {
        logic accept;
        logic resp;
        logic read;
        logic rd_last_clr;
        logic clr_all;
        logic incr;
        logic lam_on;
        logic lam_off;
    } dec_t;
endpackage

// File: rtl/dw_decode.sv
module dw_decode
    import dw_func_pkg::*;
#(
    parameter int NCH = 12,
    parameter int AW  = 4
) (
    input  logic            stn_sel,
    input  logic [AW-1:0]   sub_addr,
    input  logic [FN_W-1:0] func,
    input  logic            lam_flag,
    output dec_t            dec
);
    localparam int LAST_CH = NCH - 1;

    logic addr_ok;
    logic fn_known;

    assign addr_ok = int'(sub_addr) < NCH;

    always_comb begin
        unique case (func)
            FN_READ, FN_READ_CLR, FN_TEST_LAM, FN_CLEAR,
            FN_LAM_OFF, FN_INCR, FN_LAM_ON: fn_known = 1'b1;
            default:                        fn_known = 1'b0;
        endcase
    end

    always_comb begin
        dec             = '0;
        dec.accept      = stn_sel && addr_ok && fn_known;
        dec.read        = stn_sel && addr_ok && (func == FN_READ || func == FN_READ_CLR);
        dec.resp        = dec.read || (stn_sel && addr_ok && func == FN_TEST_LAM && lam_flag);
        dec.rd_last_clr = stn_sel && func == FN_READ_CLR && int'(sub_addr) == LAST_CH;
        dec.clr_all     = stn_sel && addr_ok && func == FN_CLEAR;
        dec.incr        = stn_sel && addr_ok && func == FN_INCR;
        dec.lam_on      = stn_sel && addr_ok && func == FN_LAM_ON;
        dec.lam_off     = stn_sel && addr_ok && func == FN_LAM_OFF;
    end

    always_comb begin
        assert_q_needs_x_R8: assert (dec.accept || !dec.resp)
            else $error("Q without X");
    end
endmodule

// File: rtl/dw_lam_ctrl.sv
module dw_lam_ctrl #(
    parameter int NCH = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] half_flags,
    input  logic           clr_evt,
    input  logic           clr_busy,
    input  logic           en_set,
    input  logic           en_clr,
    output logic           lam_flag,
    output logic           lam_en
);
    logic any_flag;
    assign any_flag = |half_flags;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lam_flag <= 1'b0;
        end else if (clr_evt) begin
            lam_flag <= 1'b0;
        end else if (any_flag && !clr_busy) begin
            lam_flag <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lam_en <= 1'b0;
        end else if (en_clr) begin
            lam_en <= 1'b0;
        end else if (en_set) begin
            lam_en <= 1'b1;
        end
    end

    assert_flag_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lam_flag) |-> $past(any_flag))
        else $error("LAM flag rose without a warning flag");

    assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_busy |=> !lam_flag)
        else $error("LAM flag set again right after clear");
endmodule

// File: rtl/dw_func_ctrl.sv
module dw_func_ctrl
    import dw_func_pkg::*;
#(
    parameter int NCH = 12,
    parameter int AW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stn_sel,
    input  logic [AW-1:0]   sub_addr,
    input  logic [FN_W-1:0] func,
    input  logic            strobe1,
    input  logic            strobe2,
    input  logic            crate_clear,
    input  logic            crate_init,
    input  logic            crate_inhibit,
    input  logic [NCH-1:0]  half_flags,
    output logic            x_resp,
    output logic            q_resp,
    output logic            rd_en,
    output logic [AW-1:0]   rd_sel,
    output logic            clr_pulse,
    output logic            inc_pulse,
    output logic            bank_inhibit,
    output logic            lam_req
);
    phase_t phase_q, phase_d;
    dec_t   dec;
    logic   lam_flag;
    logic   lam_en;
    logic   s2_rise;
    logic   clr_fire;
    logic   inc_fire;

    dw_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .stn_sel  (stn_sel),
        .sub_addr (sub_addr),
        .func     (func),
        .lam_flag (lam_flag),
        .dec      (dec)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (strobe2) phase_d = PH_S2;
                     else if (strobe1) phase_d = PH_S1;
            PH_S1:   if (strobe2) phase_d = PH_S2;
                     else if (!strobe1) phase_d = PH_IDLE;
            PH_S2:   if (!strobe2) phase_d = strobe1 ? PH_S1 : PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    assign s2_rise  = strobe2 && (phase_q != PH_S2);
    assign clr_fire = s2_rise && (dec.clr_all || dec.rd_last_clr || crate_clear || crate_init);
    assign inc_fire = s2_rise && dec.incr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_pulse <= 1'b0;
            inc_pulse <= 1'b0;
        end else begin
            clr_pulse <= clr_fire;
            inc_pulse <= inc_fire;
        end
    end

    dw_lam_ctrl #(.NCH(NCH)) u_lam (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_flags (half_flags),
        .clr_evt    (clr_fire),
        .clr_busy   (clr_pulse),
        .en_set     (s2_rise && dec.lam_on),
        .en_clr     (s2_rise && (dec.lam_off || crate_init)),
        .lam_flag   (lam_flag),
        .lam_en     (lam_en)
    );

    assign x_resp       = dec.accept;
    assign q_resp       = dec.resp;
    assign rd_en        = dec.read && strobe1;
    assign rd_sel       = sub_addr;
    assign bank_inhibit = crate_inhibit;
    assign lam_req      = lam_flag && lam_en && !stn_sel;

    assert_clr_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> !clr_pulse)
        else $error("clear pulse longer than one cycle");

    assert_inc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inc_pulse |=> !inc_pulse)
        else $error("increment pulse longer than one cycle");

    assert_inc_needs_station_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inc_pulse |-> $past(stn_sel) && $past(strobe2))
        else $error("increment without a selected S2 command");

    assert_clr_kills_lam_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |-> !lam_req)
        else $error("LAM request during clear pulse");
endmodule

// File: tb/tb_dw_func_ctrl.sv
module tb_dw_func_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stn_sel = 1'b0;
    logic [3:0] sub_addr = '0;
    logic [4:0] func = '0;
    logic strobe1 = 1'b0, strobe2 = 1'b0;
    logic crate_clear = 1'b0, crate_init = 1'b0, crate_inhibit = 1'b0;
    logic [NCH-1:0] half_flags = '0;
    logic x_resp, q_resp, rd_en, clr_pulse, inc_pulse, bank_inhibit, lam_req;
    logic [3:0] rd_sel;

    int checks = 0;
    int errors = 0;
    logic got_clr, got_inc;

    always #(CLK_PERIOD/2) clk = ~clk;

    dw_func_ctrl dut (
        .clk(clk), .rst_n(rst_n), .stn_sel(stn_sel), .sub_addr(sub_addr),
        .func(func), .strobe1(strobe1), .strobe2(strobe2),
        .crate_clear(crate_clear), .crate_init(crate_init),
        .crate_inhibit(crate_inhibit), .half_flags(half_flags),
        .x_resp(x_resp), .q_resp(q_resp), .rd_en(rd_en), .rd_sel(rd_sel),
        .clr_pulse(clr_pulse), .inc_pulse(inc_pulse),
        .bank_inhibit(bank_inhibit), .lam_req(lam_req)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    // One dataway command; pulses sampled in the cycle after the S2 rise,
    // then S2 is held one more cycle to confirm no second pulse.
    task automatic dw_cmd(input int f, input int a, input bit n, input bit c, input bit z);
        @(negedge clk);
        stn_sel = n; func = 5'(f); sub_addr = 4'(a);
        crate_clear = c; crate_init = z; strobe1 = 1'b1;
        @(negedge clk);
        strobe2 = 1'b1;
        @(negedge clk);
        got_clr = clr_pulse; got_inc = inc_pulse;
        @(negedge clk);
        chk_eq("R13 clr no repeat", int'(clr_pulse), 0);
        chk_eq("R13 inc no repeat", int'(inc_pulse), 0);
        strobe1 = 1'b0; strobe2 = 1'b0;
        @(negedge clk);
        stn_sel = 1'b0; crate_clear = 1'b0; crate_init = 1'b0;
        func = '0; sub_addr = '0;
    endtask

    function automatic bit fn_ok(input int f);
        return f == 0 || f == 2 || f == 8 || f == 9 || f == 24 || f == 25 || f == 26;
    endfunction

    task automatic lam_test_q(input int exp, input string tag);
        @(negedge clk);
        stn_sel = 1'b1; func = 5'd8; sub_addr = 4'd5;
        #1;
        chk_eq(tag, int'(q_resp), exp);
        chk_eq("R4 test X", int'(x_resp), 1);
        stn_sel = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk_eq("R1 clr", int'(clr_pulse), 0);
        chk_eq("R1 inc", int'(inc_pulse), 0);
        chk_eq("R1 lam", int'(lam_req), 0);
        chk_eq("R1 x", int'(x_resp), 0);
        chk_eq("R1 q", int'(q_resp), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R8 sweep of every code combination
        for (int n = 0; n < 2; n++) begin
            for (int f = 0; f < 32; f++) begin
                for (int a = 0; a < 16; a++) begin
                    stn_sel = n[0]; func = 5'(f); sub_addr = 4'(a); strobe1 = 1'b1;
                    #1;
                    chk_eq("R8 x", int'(x_resp), int'(n == 1 && a < 12 && fn_ok(f)));
                    chk_eq("R8 q", int'(q_resp), int'(n == 1 && a < 12 && (f == 0 || f == 2)));
                    chk_eq("R2 rd_en", int'(rd_en), int'(n == 1 && a < 12 && (f == 0 || f == 2)));
                    chk_eq("R2 rd_sel", int'(rd_sel), a);
                end
            end
        end
        strobe1 = 1'b0; stn_sel = 1'b0;
        #1 chk_eq("R2 rd_en off without S1", int'(rd_en), 0);

        // R3 read-and-clear only on the last subaddress
        dw_cmd(2, 11, 1, 0, 0);
        chk_eq("R3 clr at A11", int'(got_clr), 1);
        for (int a = 0; a < 11; a++) begin
            dw_cmd(2, a, 1, 0, 0);
            chk_eq("R3 no clr below A11", int'(got_clr), 0);
        end
        dw_cmd(0, 11, 1, 0, 0);
        chk_eq("R3 plain read no clr", int'(got_clr), 0);

        // R6 increment
        dw_cmd(25, 3, 1, 0, 0);
        chk_eq("R6 inc", int'(got_inc), 1);
        chk_eq("R6 no clr", int'(got_clr), 0);
        dw_cmd(25, 13, 1, 0, 0);
        chk_eq("R6 bad A no inc", int'(got_inc), 0);

        // R10 flag latches; R4 test ignores enable
        half_flags = 12'h040;
        @(negedge clk);
        half_flags = '0;
        @(negedge clk);
        chk_eq("R10 masked while disabled", int'(lam_req), 0);
        lam_test_q(1, "R4 test with enable off");

        // R7 enable latch
        dw_cmd(26, 0, 1, 0, 0);
        @(negedge clk);
        chk_eq("R10 lam_req with enable", int'(lam_req), 1);
        stn_sel = 1'b1;
        #1 chk_eq("R10 masked by N", int'(lam_req), 0);
        stn_sel = 1'b0;

        // R5 function 9 clear
        dw_cmd(9, 7, 1, 0, 0);
        chk_eq("R5 clr", int'(got_clr), 1);
        chk_eq("R5 lam cleared", int'(lam_req), 0);
        lam_test_q(0, "R5 flag cleared");

        // R11 clear wins over a flag still high
        half_flags = 12'h801;
        @(negedge clk);
        @(negedge clk);
        chk_eq("R10 set again", int'(lam_req), 1);
        crate_clear = 1'b1; strobe2 = 1'b1;
        @(negedge clk);
        chk_eq("R9 C pulse w/o N", int'(clr_pulse), 1);
        chk_eq("R11 lam low during clear", int'(lam_req), 0);
        @(negedge clk);
        chk_eq("R11 lam low after clear", int'(lam_req), 0);
        half_flags = '0; crate_clear = 1'b0; strobe2 = 1'b0;
        @(negedge clk);
        chk_eq("R11 lam stays low", int'(lam_req), 0);
        lam_test_q(0, "R11 flag low");

        // R7 enable survives C; R9 Z clears it
        half_flags = 12'h002;
        @(negedge clk);
        half_flags = '0;
        @(negedge clk);
        chk_eq("R7 enable held after C", int'(lam_req), 1);
        dw_cmd(0, 0, 0, 0, 1);
        chk_eq("R9 Z clr", int'(got_clr), 1);
        half_flags = 12'h002;
        @(negedge clk);
        half_flags = '0;
        @(negedge clk);
        chk_eq("R9 Z disables enable", int'(lam_req), 0);
        lam_test_q(1, "R4 flag set with enable off");
        dw_cmd(26, 11, 1, 0, 0);
        @(negedge clk);
        chk_eq("R7 enable on", int'(lam_req), 1);
        dw_cmd(24, 11, 1, 0, 0);
        @(negedge clk);
        chk_eq("R7 enable off by 24", int'(lam_req), 0);

        // R12 inhibit pass-through
        crate_inhibit = 1'b1;
        #1 chk_eq("R12 inhibit on", int'(bank_inhibit), 1);
        crate_inhibit = 1'b0;
        #1 chk_eq("R12 inhibit off", int'(bank_inhibit), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule